// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block chooses whether the chip runs from its main supply or from its backup battery. It does not measure any voltage. Four comparator outputs arrive as digital flags. Two of them report that the main supply is low: it is below the battery voltage less a hysteresis margin of about 50 mV, and it is below a trip level of about 2.2 V. The other two report that the main supply is high again: it is above the battery voltage plus the same margin, and it is above the trip level plus about 30 mV. All four flags pass through a synchronizer before the two-state controller uses them. The registered supply-select output then drives the external power switches.

A small configuration register sets two things. The first is which switchover rule applies. Standard mode moves to the battery only when the main supply is below both references, and moves back when either of the upper flags is set. Legacy mode is the reset default and looks only at the battery comparison. The second setting decides whether the serial bus interface stays enabled while the chip runs on the battery. When the chip is on the main supply, the bus is always enabled.

Top module: `bkp_switchover`

## Requirements
- R1: While `rst` is high and after it is released, `supply_batt` is 0 and `bus_en` is 1. The configuration register resets to legacy mode with the bus-keep bit at 0.
- R2: In standard mode (`cfg_legacy`=0 stored), the controller leaves main-supply mode only when the synchronized `vdd_lt_batt` and `vdd_lt_trip` are both 1.
- R3: In standard mode, the controller leaves battery mode when the synchronized `vdd_gt_batt` or `vdd_gt_trip` is 1.
- R4: In legacy mode (`cfg_legacy`=1 stored), the controller enters battery mode on `vdd_lt_batt` alone and returns on `vdd_gt_batt` alone. The trip flags have no effect.
- R5: A flag change driven before clock edge k first shows on `supply_batt` after edge k+2: two synchronizer stages, then the state register.
- R6: `bus_en` is 1 whenever `supply_batt` is 0.
- R7: While `supply_batt` is 1, `bus_en` equals the stored bus-keep bit.
- R8: A clock edge with `cfg_wr`=1 loads `cfg_legacy` and `cfg_bus_keep`. While `cfg_wr`=0, changes on those inputs have no effect.
- R9: `supply_batt` is 1 for battery backup and 0 for the main supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_lt_batt | input | 1 | Main supply below battery minus hysteresis (asynchronous) |
| vdd_lt_trip | input | 1 | Main supply below trip level (asynchronous) |
| vdd_gt_batt | input | 1 | Main supply above battery plus hysteresis (asynchronous) |
| vdd_gt_trip | input | 1 | Main supply above trip level plus its hysteresis (asynchronous) |
| cfg_wr | input | 1 | Load strobe for the configuration bits |
| cfg_legacy | input | 1 | Switchover rule: 1 legacy, 0 standard |
| cfg_bus_keep | input | 1 | 1 keeps the bus enabled in battery mode |
| supply_batt | output | 1 | Supply select, 1 = battery |
| bus_en | output | 1 | Serial bus interface enable |

## Verification
The hold properties look at the synchronized flags and the stored configuration. They assume the comparators never report contradictory levels, so a "below" flag and its matching "above" flag are never set together. Contradictory flags would let a correct design move between states every cycle. The sweeps therefore use only the nine consistent flag combinations for each mode, starting state and bus-keep setting. Each combination is held long enough for the synchronizer to settle before the outputs are compared with the rule computed in the bench.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } src_e;

  typedef struct packed {
    logic lt_batt;
    logic lt_trip;
    logic gt_batt;
    logic gt_trip;
  } cmp_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(cmp_flags_t);

endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/bkp_cfg_reg.sv
module bkp_cfg_reg #(
  parameter logic LEGACY_RST = 1'b1,
  parameter logic KEEP_RST   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic legacy_d,
  input  logic keep_d,
  output logic legacy_q,
  output logic keep_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      legacy_q <= LEGACY_RST;
      keep_q   <= KEEP_RST;
    end else if (wr) begin
      legacy_q <= legacy_d;
      keep_q   <= keep_d;
    end
  end

endmodule

// File: rtl/bkp_mode_fsm.sv
module bkp_mode_fsm
  import bkp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmp_flags_t flags,
  input  logic       legacy,
  input  logic       keep,
  output logic       on_batt,
  output logic       bus_en
);

  src_e state_q, state_d;
  logic enter_batt, leave_batt;

  always_comb begin
    if (legacy) begin
      enter_batt = flags.lt_batt;
      leave_batt = flags.gt_batt;
    end else begin
      enter_batt = flags.lt_batt & flags.lt_trip;
      leave_batt = flags.gt_batt | flags.gt_trip;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_MAIN: if (enter_batt) state_d = SRC_BATT;
      SRC_BATT: if (leave_batt) state_d = SRC_MAIN;
      default:  state_d = SRC_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_MAIN;
      bus_en  <= 1'b1;
    end else begin
      state_q <= state_d;
      bus_en  <= (state_d == SRC_BATT) ? keep : 1'b1;
    end
  end

  assign on_batt = (state_q == SRC_BATT);

endmodule

// File: rtl/bkp_switchover.sv
module bkp_switchover
  import bkp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        LEGACY_RST  = 1'b1,
  parameter logic        KEEP_RST    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_lt_batt,
  input  logic vdd_lt_trip,
  input  logic vdd_gt_batt,
  input  logic vdd_gt_trip,
  input  logic cfg_wr,
  input  logic cfg_legacy,
  input  logic cfg_bus_keep,
  output logic supply_batt,
  output logic bus_en
);

  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_sync;
  logic                 legacy_q;
  logic                 keep_q;

  assign flags_raw = {vdd_lt_batt, vdd_lt_trip, vdd_gt_batt, vdd_gt_trip};

  bkp_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (flags_raw),
    .q_sync  (flags_sync)
  );

  bkp_cfg_reg #(
    .LEGACY_RST (LEGACY_RST),
    .KEEP_RST   (KEEP_RST)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .legacy_d (cfg_legacy),
    .keep_d   (cfg_bus_keep),
    .legacy_q (legacy_q),
    .keep_q   (keep_q)
  );

  bkp_mode_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .flags   (cmp_flags_t'(flags_sync)),
    .legacy  (legacy_q),
    .keep    (keep_q),
    .on_batt (supply_batt),
    .bus_en  (bus_en)
  );

endmodule

// File: rtl/bkp_switchover_chk.sv
module bkp_switchover_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_batt,
  input logic       bus_en,
  input logic       legacy_q,
  input logic       keep_q,
  input logic [3:0] flags_sync
);

  logic s_lt_batt, s_lt_trip, s_gt_batt, s_gt_trip;
  assign {s_lt_batt, s_lt_trip, s_gt_batt, s_gt_trip} = flags_sync;

  logic was_rst = 1'b0;
  always_ff @(posedge clk) was_rst <= rst;

  AST_RESET_MAIN: assert property (@(posedge clk)
    was_rst |-> (!supply_batt && bus_en)); // R1

  AST_STD_ENTER_AND: assert property (@(posedge clk) disable iff (rst)
    (!supply_batt && !legacy_q && !(s_lt_batt && s_lt_trip)) |=> !supply_batt); // R2

  AST_STD_EXIT_OR: assert property (@(posedge clk) disable iff (rst)
    (supply_batt && !legacy_q && !s_gt_batt && !s_gt_trip) |=> supply_batt); // R3

  AST_LEG_ENTER: assert property (@(posedge clk) disable iff (rst)
    (!supply_batt && legacy_q && !s_lt_batt) |=> !supply_batt); // R4

  AST_LEG_EXIT: assert property (@(posedge clk) disable iff (rst)
    (supply_batt && legacy_q && !s_gt_batt) |=> supply_batt); // R4

  AST_BUS_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
    !supply_batt |-> bus_en); // R6

  AST_BUS_IN_BATT: assert property (@(posedge clk) disable iff (rst)
    supply_batt |-> (bus_en == $past(keep_q))); // R7

endmodule

bind bkp_switchover bkp_switchover_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_batt (supply_batt),
  .bus_en      (bus_en),
  .legacy_q    (legacy_q),
  .keep_q      (keep_q),
  .flags_sync  (flags_sync)
);

// File: tb/bkp_switchover_test.sv
module bkp_switchover_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lt_b = 1'b0, lt_t = 1'b0, gt_b = 1'b0, gt_t = 1'b0;
  logic cfg_wr = 1'b0, cfg_legacy = 1'b0, cfg_keep = 1'b0;
  logic supply_batt, bus_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  bkp_switchover uut (
    .clk          (clk),
    .rst          (rst),
    .vdd_lt_batt  (lt_b),
    .vdd_lt_trip  (lt_t),
    .vdd_gt_batt  (gt_b),
    .vdd_gt_trip  (gt_t),
    .cfg_wr       (cfg_wr),
    .cfg_legacy   (cfg_legacy),
    .cfg_bus_keep (cfg_keep),
    .supply_batt  (supply_batt),
    .bus_en       (bus_en)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_flags(input logic a, input logic b, input logic c, input logic d);
    lt_b = a; lt_t = b; gt_b = c; gt_t = d;
  endtask

  task automatic write_cfg(input logic leg, input logic keep);
    cfg_legacy = leg; cfg_keep = keep; cfg_wr = 1'b1;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(3);
    // R1: outputs while reset is held
    check("R1", "supply in reset", supply_batt, 1'b0);
    check("R1", "bus_en in reset", bus_en, 1'b1);
    // R8: inputs ignored without strobe
    cfg_legacy = 1'b0; cfg_keep = 1'b1; cfg_wr = 1'b0;
    rst = 1'b0;
    cyc(1);
    check("R1", "supply after reset", supply_batt, 1'b0);
    check("R1", "bus_en after reset", bus_en, 1'b1);
    // R1/R8: legacy default and keep=0 still in force: lt_batt alone enters battery
    set_flags(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(5);
    check("R8", "legacy default kept without cfg_wr", supply_batt, 1'b1);
    check("R1", "keep default 0 gives bus off", bus_en, 1'b0);
    check("R9", "battery encoding", supply_batt, 1'b1);
    set_flags(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(5);
    check("R9", "main encoding", supply_batt, 1'b0);

    // R5: latency in standard mode
    write_cfg(1'b0, 1'b1);
    cyc(4);
    set_flags(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1);
    check("R5", "supply after 1 edge", supply_batt, 1'b0);
    cyc(1);
    check("R5", "supply after 2 edges", supply_batt, 1'b0);
    cyc(1);
    check("R5", "supply after 3 edges", supply_batt, 1'b1);
    check("R7", "bus_en with keep=1 at entry", bus_en, 1'b1);

    // Sweep: mode x start state x keep x consistent flag combos
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 2; k++) begin
        write_cfg(m[0], k[0]);
        for (int st = 0; st < 2; st++) begin
          for (int lo = 0; lo < 3; lo++) begin
            for (int hi = 0; hi < 3; hi++) begin
              logic a, b, c, d, exp_s, exp_b;
              string tag;
              // lo: battery comparison 0 none,1 below,2 above; hi: trip comparison likewise
              a = (lo == 1); c = (lo == 2);
              b = (hi == 1); d = (hi == 2);
              if (st == 1) set_flags(1'b1, 1'b1, 1'b0, 1'b0);
              else         set_flags(1'b0, 1'b0, 1'b1, 1'b1);
              cyc(5);
              check(st == 1 ? "R3" : "R2", "start state", supply_batt, st[0]);
              set_flags(a, b, c, d);
              cyc(5);
              if (m == 1) begin
                tag = "R4";
                exp_s = (st == 1) ? !c : a;
              end else if (st == 0) begin
                tag = "R2";
                exp_s = a & b;
              end else begin
                tag = "R3";
                exp_s = !(c | d);
              end
              check(tag, $sformatf("supply m=%0d st=%0d flags=%b%b%b%b", m, st, a, b, c, d),
                    supply_batt, exp_s);
              exp_b = exp_s ? k[0] : 1'b1;
              check(exp_s ? "R7" : "R6", $sformatf("bus_en m=%0d k=%0d", m, k), bus_en, exp_b);
            end
          end
        end
      end
    end

    // R7/R8: keep bit changes while staying in battery
    write_cfg(1'b0, 1'b0);
    set_flags(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(5);
    check("R7", "keep=0 in battery", bus_en, 1'b0);
    write_cfg(1'b0, 1'b1);
    cyc(2);
    check("R8", "keep written to 1 in battery", bus_en, 1'b1);
    cfg_keep = 1'b0;
    cyc(3);
    check("R8", "keep change without strobe ignored", bus_en, 1'b1);

    // R1: reset from battery returns to main
    rst = 1'b1;
    cyc(1);
    check("R1", "reset from battery", supply_batt, 1'b0);
    check("R1", "bus_en on reset from battery", bus_en, 1'b1);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule